// File: doc/BRIEF.md
# Downstream Port Power Manager

This block switches power to the four downstream ports of a hub and watches the overcurrent flag returned by each port's external power switch. The hub controller sends it single-cycle power-on and power-off requests for each port. The block drives one active-low enable per port to the external switches and returns a filtered overcurrent status bit and a sticky change bit for each port.

Each overcurrent pin is resynchronised into the clock domain. A counter then filters it, so a level must hold for a set number of clocks before the block accepts it. A strap input chooses how the ports are managed, and it is captured only while reset is held:

- **Individual mode:** every port is controlled on its own.
- **Ganged mode:** the four enables always switch together, and an overcurrent on any pin removes power from all ports.

An overcurrent shut-down latches. Power returns only when the controller asks for it again after the fault has cleared.

Top module: `hub_port_power`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every enable output is driven high (port unpowered), and all status and change bits read 0.
- R2: An overcurrent pin is active low. A low level shows on that port's status bit (1 = overcurrent) only after the pin has held low for FILT_CYCLES consecutive clocks. The status bit changes on the (FILT_CYCLES+2)-th rising edge after the pin changes. The same rule applies when the pin returns high.
- R3: A pulse on an overcurrent pin lasting fewer than FILT_CYCLES clocks changes no status bit, no change bit and no enable.
- R4: In individual mode, a power-on request bit i drives enable i low on the next edge. A power-off request bit i drives it high. When both arrive together, the power-off request wins. Other ports are not affected.
- R5: In individual mode, a port whose status bit is 1 has its enable driven high on the next edge. No other port's enable is affected.
- R6: A port switched off by an overcurrent stays off after the fault clears, until a new power-on request arrives. A power-on request made while that port's status bit is 1 is ignored.
- R7: In ganged mode, a power-on request on any port drives all four enables low. A power-off request on any port drives all four high.
- R8: In ganged mode, a filtered overcurrent on any pin sets all four status bits and drives all four enables high on the next edge.
- R9: Change bit i is set one edge after any rise or fall of status bit i. It stays set until a clear pulse on bit i, which clears it on the next edge.
- R10: The mode strap (1 = ganged, 0 = individual) is sampled only while reset is low. Changing it after reset has no effect on behaviour.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gang_mode_i | input | 1 | Mode strap, 1 = ganged, sampled during reset |
| pwr_on_req_i | input | 4 | Per-port power-on request pulses |
| pwr_off_req_i | input | 4 | Per-port power-off request pulses |
| oc_n_i | input | 4 | Active-low overcurrent pins from the external switches |
| oc_chg_clr_i | input | 4 | Per-port change-bit clear pulses |
| pwr_en_n_o | output | 4 | Active-low power enables, always driven |
| oc_stat_o | output | 4 | Filtered overcurrent status, 1 = overcurrent |
| oc_chg_o | output | 4 | Sticky overcurrent change flags |

## Verification
A wrong filter counter or synchroniser depth shows up as a status bit that moves one or more edges off the FILT_CYCLES+2 mark. A wrong filter can also let a short spike through, which appears within FILT_CYCLES+2 edges of the spike. A corrupted power bit or mode latch shows on the enable outputs one edge after the request or fault that exposes it. In ganged mode the enables split, or a port comes back without a request. A lost change edge stays visible on the sticky flag until the next clear, so it is caught one edge after the status transition that should have set it.

// File: rtl/hpp_pkg.sv
// Package: shared types for the downstream port power manager.
// Assumes: nothing beyond IEEE 1800-2017.
package hpp_pkg;
    typedef enum logic {
        PORT_MODE_INDIV  = 1'b0,
        PORT_MODE_GANGED = 1'b1
    } port_mode_e;
endpackage

// File: rtl/oc_filter.sv
// Module: oc_filter
// Resynchronises one active-low overcurrent pin through two flops and accepts
// a new level only after it has held for FILT_CYCLES consecutive clocks.
// Output is active high (1 = overcurrent).
// Assumes: FILT_CYCLES >= 2, synchronous active-low reset.
module oc_filter #(
    parameter int FILT_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_n_i,
    output logic oc_o
);
    localparam int CNT_W = $clog2(FILT_CYCLES + 1);

    logic             sync1_q, sync2_q;
    logic             flt_q;
    logic [CNT_W-1:0] cnt_q;

    // Two-flop synchroniser, stored active high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= ~oc_n_i;
            sync2_q <= sync1_q;
        end
    end

    // Stability counter: adopt the synced level after FILT_CYCLES differing clocks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            flt_q <= 1'b0;
        end else if (sync2_q == flt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CNT_W'(FILT_CYCLES - 1)) begin
            cnt_q <= '0;
            flt_q <= sync2_q;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign oc_o = flt_q;

    // R3
    filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q != $past(flt_q)) |-> ($past(cnt_q) == CNT_W'(FILT_CYCLES - 1)));

    // R2
    filt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_q != $past(flt_q)) |-> (flt_q == $past(sync2_q)));
endmodule

// File: rtl/port_pwr_ctrl.sv
// Module: port_pwr_ctrl
// Holds the per-port power state and applies ganged or individual rules.
// Priority per port: overcurrent > off request > on request.
// Assumes: gang_mode_i is static; it is captured only while reset is low.
module port_pwr_ctrl
    import hpp_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gang_mode_i,
    input  logic [NPORTS-1:0] on_req_i,
    input  logic [NPORTS-1:0] off_req_i,
    input  logic [NPORTS-1:0] oc_flt_i,
    output logic [NPORTS-1:0] pwr_on_o,
    output logic [NPORTS-1:0] oc_eff_o
);
    port_mode_e        mode_q;
    logic [NPORTS-1:0] on_q, on_d, oc_eff;
    logic [NPORTS-1:0] on_eff, off_eff;
    logic              any_oc, any_on, any_off;

    // Capture the mode strap during reset only.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= port_mode_e'(gang_mode_i);
    end

    assign any_oc  = |oc_flt_i;
    assign any_on  = |on_req_i;
    assign any_off = |off_req_i;

    // Spread faults and requests across ports in ganged mode.
    always_comb begin
        for (int i = 0; i < NPORTS; i++) begin
            if (mode_q == PORT_MODE_GANGED) begin
                oc_eff[i]  = any_oc;
                on_eff[i]  = any_on;
                off_eff[i] = any_off;
            end else begin
                oc_eff[i]  = oc_flt_i[i];
                on_eff[i]  = on_req_i[i];
                off_eff[i] = off_req_i[i];
            end
        end
    end

    // Next power state per port.
    always_comb begin
        for (int i = 0; i < NPORTS; i++) begin
            if (oc_eff[i] || off_eff[i]) on_d[i] = 1'b0;
            else if (on_eff[i])          on_d[i] = 1'b1;
            else                         on_d[i] = on_q[i];
        end
    end

    // Power state register, all ports off at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) on_q <= '0;
        else        on_q <= on_d;
    end

    assign pwr_on_o = on_q;
    assign oc_eff_o = oc_eff;

    // R8
    gang_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == PORT_MODE_GANGED) |-> ($countones(on_q) == 0 || $countones(on_q) == NPORTS));

    // R10
    mode_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode_q));

    generate
        for (genvar g = 0; g < NPORTS; g++) begin : g_chk
            // R5
            oc_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
                oc_eff[g] |=> !on_q[g]);
            // R6
            on_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (on_q[g] && !$past(on_q[g])) |-> ($past(on_eff[g]) && !$past(oc_eff[g])));
        end
    endgenerate
endmodule

// File: rtl/oc_change_log.sv
// Module: oc_change_log
// Sticky per-port flag that sets on any edge of the effective overcurrent
// status and clears on a controller pulse; a new edge wins over a clear.
// Assumes: synchronous active-low reset; status is 0 at reset.
module oc_change_log #(
    parameter int NPORTS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPORTS-1:0] oc_eff_i,
    input  logic [NPORTS-1:0] clr_i,
    output logic [NPORTS-1:0] chg_o
);
    logic [NPORTS-1:0] prev_q, chg_q;

    // Remember last status to detect its edges.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= oc_eff_i;
    end

    // Sticky change flags.
    always_ff @(posedge clk) begin
        if (!rst_n) chg_q <= '0;
        else        chg_q <= (oc_eff_i ^ prev_q) | (chg_q & ~clr_i);
    end

    assign chg_o = chg_q;

    generate
        for (genvar g = 0; g < NPORTS; g++) begin : g_chk
            // R9
            chg_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(chg_q[g]) && !$past(clr_i[g])) |-> chg_q[g]);
            // R9
            chg_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (oc_eff_i[g] != prev_q[g]) |=> chg_q[g]);
        end
    endgenerate
endmodule

// File: rtl/hub_port_power.sv
// Module: hub_port_power (top)
// Downstream port power manager: per-port overcurrent filters, power state
// control with ganged/individual mode, and sticky change reporting.
// Assumes: gang_mode_i static after reset; request and clear inputs are pulses.
module hub_port_power #(
    parameter int NPORTS      = 4,
    parameter int FILT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gang_mode_i,
    input  logic [NPORTS-1:0] pwr_on_req_i,
    input  logic [NPORTS-1:0] pwr_off_req_i,
    input  logic [NPORTS-1:0] oc_n_i,
    input  logic [NPORTS-1:0] oc_chg_clr_i,
    output logic [NPORTS-1:0] pwr_en_n_o,
    output logic [NPORTS-1:0] oc_stat_o,
    output logic [NPORTS-1:0] oc_chg_o
);
    logic [NPORTS-1:0] oc_flt, oc_eff, pwr_on;

    // One filter per overcurrent pin.
    generate
        for (genvar g = 0; g < NPORTS; g++) begin : g_filt
            oc_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
                .clk    (clk),
                .rst_n  (rst_n),
                .oc_n_i (oc_n_i[g]),
                .oc_o   (oc_flt[g])
            );
        end
    endgenerate

    port_pwr_ctrl #(.NPORTS(NPORTS)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .gang_mode_i (gang_mode_i),
        .on_req_i    (pwr_on_req_i),
        .off_req_i   (pwr_off_req_i),
        .oc_flt_i    (oc_flt),
        .pwr_on_o    (pwr_on),
        .oc_eff_o    (oc_eff)
    );

    oc_change_log #(.NPORTS(NPORTS)) u_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .oc_eff_i (oc_eff),
        .clr_i    (oc_chg_clr_i),
        .chg_o    (oc_chg_o)
    );

    assign pwr_en_n_o = ~pwr_on;
    assign oc_stat_o  = oc_eff;

    // R1
    reset_off_chk: assert property (@(posedge clk)
        !rst_n |=> (pwr_en_n_o == '1 && oc_chg_o == '0));
endmodule

// File: tb/tb_hub_port_power.sv
module tb_hub_port_power;
    localparam int N = 4;
    localparam int F = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         gang = 1'b0;
    logic [N-1:0] on_req = '0, off_req = '0, oc_n = '1, clr = '0;
    logic [N-1:0] en_n, stat, chg;

    int checks = 0, errors = 0;
    bit model_live = 0;

    hub_port_power #(.NPORTS(N), .FILT_CYCLES(F)) dut (
        .clk(clk), .rst_n(rst_n), .gang_mode_i(gang),
        .pwr_on_req_i(on_req), .pwr_off_req_i(off_req),
        .oc_n_i(oc_n), .oc_chg_clr_i(clr),
        .pwr_en_n_o(en_n), .oc_stat_o(stat), .oc_chg_o(chg)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model: pin history queues, integer run lengths.
    bit       m_gang;
    bit [N-1:0] m_flt, m_on, m_chg, m_prev;
    int       m_run [N];
    bit       m_pipe [N][$];

    function automatic bit [N-1:0] m_eff();
        return (m_gang && (m_flt != 0)) ? '1 : (m_gang ? '0 : m_flt);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_gang = gang; m_flt = '0; m_on = '0; m_chg = '0; m_prev = '0;
            for (int i = 0; i < N; i++) begin
                m_run[i] = 0;
                m_pipe[i] = '{0, 0};
            end
        end else begin
            bit [N-1:0] eff;
            bit aon, aoff;
            eff = m_eff();
            aon = (on_req != 0); aoff = (off_req != 0);
            for (int i = 0; i < N; i++) begin
                bit onr, offr;
                onr  = m_gang ? aon  : on_req[i];
                offr = m_gang ? aoff : off_req[i];
                if (eff[i] || offr) m_on[i] = 0;
                else if (onr)       m_on[i] = 1;
                if (eff[i] != m_prev[i]) m_chg[i] = 1;
                else if (clr[i])         m_chg[i] = 0;
            end
            m_prev = eff;
            for (int i = 0; i < N; i++) begin
                bit lvl;
                lvl = m_pipe[i][0];
                if (lvl != m_flt[i]) begin
                    m_run[i]++;
                    if (m_run[i] == F) begin m_flt[i] = lvl; m_run[i] = 0; end
                end else m_run[i] = 0;
                void'(m_pipe[i].pop_front());
                m_pipe[i].push_back(~oc_n[i]);
            end
        end
        model_live = 1;
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (model_live) begin
            chk("R4/R5/R7/R8 model enables", en_n, ~m_on);
            chk("R2/R3/R8 model status", stat, m_eff());
            chk("R9 model change", chg, m_chg);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_on(input logic [N-1:0] v);
        on_req = v; cyc(1); on_req = '0;
    endtask

    task automatic do_reset(input logic g);
        rst_n = 1'b0; gang = g; cyc(4); rst_n = 1'b1;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        chk("R1 reset enables", en_n, 4'b1111);
        chk("R1 reset status", stat, 4'b0000);
        chk("R1 reset change", chg, 4'b0000);

        // R4 individual control and off priority
        pulse_on(4'b0101);
        chk("R4 on ports 0,2", en_n, 4'b1010);
        on_req = 4'b0011; off_req = 4'b0001; cyc(1); on_req = '0; off_req = '0;
        chk("R4 off wins on port0", en_n, 4'b1001);

        // R3 short spike on port1
        oc_n = 4'b1101; cyc(F - 1); oc_n = 4'b1111; cyc(F + 6);
        chk("R3 spike status", stat, 4'b0000);
        chk("R3 spike change", chg, 4'b0000);
        chk("R3 spike enables", en_n, 4'b1001);

        // R2 filter timing, R5 per-port shutdown
        oc_n = 4'b1011; cyc(F + 1);
        chk("R2 not yet accepted", stat, 4'b0000);
        cyc(1);
        chk("R2 accepted", stat, 4'b0100);
        cyc(1);
        chk("R5 only port2 off", en_n, 4'b1101);
        chk("R9 set on rise", chg, 4'b0100);
        pulse_on(4'b0100);
        chk("R6 on ignored during fault", en_n, 4'b1101);
        clr = 4'b0100; cyc(1); clr = '0;
        chk("R9 cleared", chg, 4'b0000);
        oc_n = 4'b1111; cyc(F + 4);
        chk("R2 release status", stat, 4'b0000);
        chk("R9 set on fall", chg, 4'b0100);
        chk("R6 stays off after release", en_n, 4'b1101);
        clr = 4'b1111; cyc(1); clr = '0;
        pulse_on(4'b0100);
        chk("R6 repowered by request", en_n, 4'b1001);

        // R10 strap change after reset ignored
        gang = 1'b1;
        oc_n = 4'b1101; cyc(F + 4);
        chk("R10 still individual enables", en_n, 4'b1011);
        chk("R10 still individual status", stat, 4'b0010);
        oc_n = 4'b1111; cyc(F + 4);
        clr = 4'b1111; cyc(1); clr = '0;

        // Ganged mode
        do_reset(1'b1);
        gang = 1'b0;
        chk("R1 reset enables ganged", en_n, 4'b1111);
        pulse_on(4'b0010);
        chk("R7 any on powers all", en_n, 4'b0000);
        off_req = 4'b1000; cyc(1); off_req = '0;
        chk("R7 any off removes all", en_n, 4'b1111);
        pulse_on(4'b0001);
        oc_n = 4'b0111; cyc(F + 3);
        chk("R8 status on every port", stat, 4'b1111);
        chk("R8 all powered off", en_n, 4'b1111);
        chk("R9 ganged change", chg, 4'b1111);
        oc_n = 4'b1111; cyc(F + 4);
        chk("R6 ganged stays off", en_n, 4'b1111);
        pulse_on(4'b0100);
        chk("R7 ganged repower", en_n, 4'b0000);
        cyc(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule